// File: doc/BRIEF.md
# Dual-Pin Edge Capture Timer

This block timestamps signal transitions on two input pins. A 12-bit counter runs from a slow tick enable. On each pin, a rising edge and a falling edge each have their own 8-bit capture register, which gives four registers in all. When an edge of the matching type is detected, the register loads an 8-bit slice of the counter. A prescaler field selects which slice is stored, so software trades timing resolution against range.

Software reaches the block through a small register port. The port carries a control byte, four capture registers that clear their own valid flag when read, and a status byte that shows the valid flags. Each pin has one interrupt request, which combines that pin's two capture events through per-register enables. A hold mode keeps the earliest timestamp in a register until software services it.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, all four capture registers, the control byte, the status byte and both interrupt outputs read zero.
- R2: The counter advances by one on every clock edge where `tickEn` is high and holds otherwise. It wraps from 4095 to 0.
- R3: A level change on a pin that is set up before clock edge k is stored at edge k+2. A rise on `pinA` loads address 0, a fall on `pinA` loads address 1, a rise on `pinB` loads address 2 and a fall on `pinB` loads address 3. The other registers keep their values.
- R4: Control bits 6:4 hold a prescaler value p. For p from 0 to 4, the stored byte is counter bits [p+7:p]. For p from 5 to 7, the stored byte is counter bits [11:4].
- R5: Status register address 5 shows a valid flag in each of bits 0 to 3, one per capture register at addresses 0 to 3. A flag sets when its register captures and clears when that register is read with `regRdEn` high.
- R6: When control bit 7 (hold) is set, a register whose valid flag is set ignores further matching edges. After the register is read, the next matching edge captures again.
- R7: When hold is clear, each matching edge overwrites the earlier timestamp.
- R8: `irqA` is (valid0 AND control bit 0) OR (valid1 AND control bit 1). `irqB` is the same for valid2 and valid3 with control bits 2 and 3.
- R9: Address 4 reads back all 8 control bits and is the only writable address. Writes to addresses 0 to 3 and 5 to 7 have no effect. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable (1 MHz rate) |
| pinA | input | 1 | Asynchronous input for channel A |
| pinB | input | 1 | Asynchronous input for channel B |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe; clears the addressed valid flag |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| irqA | output | 1 | Channel A interrupt request |
| irqB | output | 1 | Channel B interrupt request |

## Verification
A bad counter or a bad window mux shows up as a wrong byte on the first capture after the fault. The prescaler table with a known tick count exposes it within a few cycles. A stuck or mis-cleared valid flag appears at the status address and on the interrupt lines in the cycle after the read or capture that should have changed it. A hold-mode fault shows as an overwritten timestamp after the second edge. Each edge is read out after the third clock, so a synchroniser of the wrong depth shows as a missing or early capture.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int TIMER_W  = 12;
  localparam int CAP_W    = 8;
  localparam int NUM_CAP  = 4;
  localparam int ADDR_W   = 3;
  localparam int SEL_W    = 3;
  localparam int MAX_SEL  = TIMER_W - CAP_W;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CAP-1:0] capLoad;
    logic [SEL_W-1:0]   winSel;
  } ect_strobe_t;
endpackage

// File: rtl/ect_ctrl.sv
module ect_ctrl
  import ect_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinA,
  input  logic                pinB,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [CAP_W-1:0]    regWrData,
  input  logic                regRdEn,
  output ect_strobe_t         strb,
  output logic [CAP_W-1:0]    ctrlQ,
  output logic [NUM_CAP-1:0]  validQ,
  output logic                irqA,
  output logic                irqB
);
  localparam int NUM_PINS = 2;
  localparam int HOLD_BIT = CAP_W - 1;

  logic [NUM_PINS-1:0] pinIn;
  logic [NUM_PINS-1:0] riseEvt;
  logic [NUM_PINS-1:0] fallEvt;
  logic [NUM_CAP-1:0]  evt;
  logic [NUM_CAP-1:0]  rdClr;

  assign pinIn = {pinB, pinA};

  // synchroniser plus one history flop per pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES:0] shiftQ;
    always_ff @(posedge clk) begin
      if (!rstN) shiftQ <= '0;
      else       shiftQ <= {shiftQ[SYNC_STAGES-1:0], pinIn[p]};
    end
    assign riseEvt[p] =  shiftQ[SYNC_STAGES-1] & ~shiftQ[SYNC_STAGES];
    assign fallEvt[p] = ~shiftQ[SYNC_STAGES-1] &  shiftQ[SYNC_STAGES];
    assign evt[2*p]   = riseEvt[p];
    assign evt[2*p+1] = fallEvt[p];
  end

  // per-register capture gating and valid flags
  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    assign strb.capLoad[c] = evt[c] & ~(ctrlQ[HOLD_BIT] & validQ[c]);
    assign rdClr[c] = regRdEn && (regAddr == ADDR_W'(c));
    always_ff @(posedge clk) begin
      if (!rstN)                validQ[c] <= 1'b0;
      else if (strb.capLoad[c]) validQ[c] <= 1'b1;
      else if (rdClr[c])        validQ[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                 ctrlQ <= '0;
    else if (regWrEn && regAddr == ADDR_CTRL)  ctrlQ <= regWrData;
  end

  // prescaler clamp
  always_comb begin
    if (ctrlQ[HOLD_BIT-1 -: SEL_W] > SEL_W'(MAX_SEL)) strb.winSel = SEL_W'(MAX_SEL);
    else                                             strb.winSel = ctrlQ[HOLD_BIT-1 -: SEL_W];
  end

  assign irqA = |(validQ[1:0] & ctrlQ[1:0]);
  assign irqB = |(validQ[3:2] & ctrlQ[3:2]);
endmodule

// File: rtl/ect_datapath.sv
module ect_datapath
  import ect_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  ect_strobe_t         strb,
  input  logic [CAP_W-1:0]    ctrlQ,
  input  logic [NUM_CAP-1:0]  validQ,
  input  logic [ADDR_W-1:0]   regAddr,
  output logic [CAP_W-1:0]    regRdData
);
  localparam int NUM_WIN = MAX_SEL + 1;

  logic [TIMER_W-1:0] timerQ;
  logic [CAP_W-1:0]   win [NUM_WIN];
  logic [CAP_W-1:0]   winData;
  logic [CAP_W-1:0]   capQ [NUM_CAP];

  always_ff @(posedge clk) begin
    if (!rstN)       timerQ <= '0;
    else if (tickEn) timerQ <= timerQ + 1'b1;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win[w] = timerQ[w+CAP_W-1:w];
  end

  always_comb begin
    winData = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (int'(strb.winSel) == w) winData = win[w];
    end
  end

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                capQ[c] <= '0;
      else if (strb.capLoad[c]) capQ[c] <= winData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (int'(regAddr) < NUM_CAP)  regRdData = capQ[regAddr[1:0]];
    else if (regAddr == ADDR_CTRL) regRdData = ctrlQ;
    else if (regAddr == ADDR_STAT) regRdData = CAP_W'(validQ);
  end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              pinA,
  input  logic              pinB,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CAP_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [CAP_W-1:0]  regRdData,
  output logic              irqA,
  output logic              irqB
);
  ect_strobe_t        strb;
  logic [CAP_W-1:0]   ctrlQ;
  logic [NUM_CAP-1:0] validQ;

  ect_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .strb(strb), .ctrlQ(ctrlQ), .validQ(validQ),
    .irqA(irqA), .irqB(irqB)
  );

  ect_datapath u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .ctrlQ(ctrlQ), .validQ(validQ), .regAddr(regAddr),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/ect_checker.sv
module ect_checker
  import ect_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               tickEn,
  input logic [TIMER_W-1:0] timerQ,
  input logic [CAP_W-1:0]   ctrlQ,
  input logic [NUM_CAP-1:0] validQ,
  input logic [NUM_CAP-1:0] capLoad,
  input logic [CAP_W-1:0]   capARise,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               irqA,
  input logic               irqB
);
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> timerQ == $past(timerQ) + 1'b1); // R2
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timerQ)); // R2
  AST_VALID_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    capLoad[2] |=> validQ[2]); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 3'd0 && !capLoad[0]) |=> !validQ[0]); // R5
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[7] && validQ[0]) |=> $stable(capARise)); // R6
  AST_IRQA_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (validQ[1:0] == 2'b00) |-> !irqA); // R8
  AST_IRQB_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (validQ[3:2] == 2'b00) |-> !irqB); // R8
endmodule

bind edge_capture_timer ect_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .timerQ(u_dp.timerQ),
  .ctrlQ(ctrlQ), .validQ(validQ), .capLoad(strb.capLoad),
  .capARise(u_dp.capQ[0]), .regRdEn(regRdEn), .regAddr(regAddr),
  .irqA(irqA), .irqB(irqB)
);

// File: tb/edge_capture_timer_bench.sv
module edge_capture_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 9;
  // {prescaler[2:0], ticks[15:0], expected byte[7:0]}
  localparam logic [26:0] VEC [NUM_VEC] = '{
    {3'd0, 16'd2748, 8'hBC}, {3'd1, 16'd2748, 8'h5E},
    {3'd2, 16'd2748, 8'hAF}, {3'd3, 16'd2748, 8'h57},
    {3'd4, 16'd2748, 8'hAB}, {3'd5, 16'd2748, 8'hAB},
    {3'd6, 16'd2748, 8'hAB}, {3'd7, 16'd2748, 8'hAB},
    {3'd0, 16'd4101, 8'h05}
  };

  logic clk = 0, rstN = 0, tickEn = 0, pinA = 0, pinB = 0;
  logic [2:0] regAddr = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic irqA, irqB;
  int nChk = 0, nBad = 0;
  logic [11:0] tmr;
  logic [7:0] v, held, afHeld;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture_timer u_edge_capture_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pinA(pinA), .pinB(pinB),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .irqA(irqA), .irqB(irqB)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; pinA = 0; pinB = 0; tickEn = 0; regWrEn = 0; regRdEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1; tmr = 0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk); tickEn = 1;
      repeat (n) @(negedge clk);
      tickEn = 0;
      tmr = tmr + 12'(n);
    end
  endtask

  task automatic setPin(bit isB, bit val);
    @(negedge clk);
    if (isB) pinB = val; else pinA = val;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 0;
    #1 d = regRdData;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    // R4 prescaler windows, R2 wrap (last entry)
    for (int i = 0; i < NUM_VEC; i++) begin
      doReset();
      wr(3'd4, {1'b0, VEC[i][26:24], 4'h0});
      ticks(int'(VEC[i][23:8]));
      setPin(0, 1);
      peek(3'd0, v);
      chk((i == NUM_VEC-1) ? "R2 wrap" : "R4 window", v, VEC[i][7:0]);
    end

    doReset();
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      peek(3'(a), v); chk("R1 reg", v, 8'h00);
    end
    chk("R1 irqA", {7'b0, irqA}, 8'h00);
    chk("R1 irqB", {7'b0, irqB}, 8'h00);

    // R3 edge routing
    ticks(8'h35); setPin(0, 1);
    peek(3'd0, v); chk("R3 A rise", v, tmr[7:0]);
    peek(3'd5, v); chk("R5 status", v, 8'h01);
    ticks(16); setPin(0, 0);
    peek(3'd1, v); chk("R3 A fall", v, tmr[7:0]);
    peek(3'd0, v); chk("R3 A rise kept", v, 8'h35);
    ticks(2); setPin(1, 1);
    peek(3'd2, v); chk("R3 B rise", v, tmr[7:0]);
    ticks(1); setPin(1, 0);
    peek(3'd3, v); chk("R3 B fall", v, tmr[7:0]);
    peek(3'd5, v); chk("R5 status all", v, 8'h0F);

    // R8 interrupts
    chk("R8 irqA off", {7'b0, irqA}, 8'h00);
    chk("R8 irqB off", {7'b0, irqB}, 8'h00);
    wr(3'd4, 8'h02);
    #1 chk("R8 irqA on", {7'b0, irqA}, 8'h01);
    chk("R8 irqB masked", {7'b0, irqB}, 8'h00);
    rd(3'd1, v);
    #1 chk("R8 irqA cleared", {7'b0, irqA}, 8'h00);
    peek(3'd5, v); chk("R5 read clears", v, 8'h0D);
    wr(3'd4, 8'h0C);
    #1 chk("R8 irqB on", {7'b0, irqB}, 8'h01);
    rd(3'd2, v);
    #1 chk("R8 irqB one left", {7'b0, irqB}, 8'h01);
    rd(3'd3, v);
    #1 chk("R8 irqB cleared", {7'b0, irqB}, 8'h00);
    rd(3'd0, v);
    peek(3'd5, v); chk("R5 all clear", v, 8'h00);

    // R7 overwrite without hold
    wr(3'd4, 8'h00);
    ticks(7); setPin(0, 1);
    setPin(0, 0); ticks(9); setPin(0, 1);
    peek(3'd0, v); chk("R7 overwrite", v, tmr[7:0]);

    // R6 hold mode
    wr(3'd4, 8'h80);
    peek(3'd1, afHeld);
    rd(3'd0, v);
    setPin(0, 0); ticks(4); setPin(0, 1);
    held = tmr[7:0];
    setPin(0, 0); ticks(5); setPin(0, 1);
    peek(3'd0, v); chk("R6 hold rise", v, held);
    peek(3'd1, v); chk("R6 hold fall", v, afHeld);
    rd(3'd0, v);
    setPin(0, 0); ticks(3); setPin(0, 1);
    peek(3'd0, v); chk("R6 after service", v, tmr[7:0]);

    // R9 register map
    peek(3'd4, v); chk("R9 ctrl readback", v, 8'h80);
    held = v;
    peek(3'd0, held);
    wr(3'd0, 8'hFF);
    peek(3'd0, v); chk("R9 write ignored", v, held);
    wr(3'd6, 8'hFF);
    peek(3'd6, v); chk("R9 addr6 zero", v, 8'h00);
    peek(3'd7, v); chk("R9 addr7 zero", v, 8'h00);
    peek(3'd4, v); chk("R9 ctrl unchanged", v, 8'h80);
    wr(3'd4, 8'hF5);
    peek(3'd4, v); chk("R9 ctrl write", v, 8'hF5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule